// File: doc/BRIEF.md
# Value-Validated Transaction Commit Engine

The engine takes finished transactions from many threads, one at a time, and makes each one atomic against a shared word memory. Each transaction arrives with two logs. The read log lists the words the thread loaded and the values it saw. The write log lists the words it wants to store and their new values. The engine reads every read-log word again from its memory and compares it with the logged value. If all of them still match, it applies the write log in order and reports a commit. If any word has changed, it drops the write log and reports an abort. The thread then runs the transaction again from its start.

The engine finds conflicts by value. It keeps no address sets and no per-thread tracking, so it can tell that a conflict happened but not which other transaction caused it. Validation and write-back of one transaction form one uninterrupted step. No other transaction is accepted until the result is out. This rules out races between transactions that validate at the same time, and it rules out livelock. Threads read the memory directly through a separate load port while they build their logs.

Top module: `txn_commit_unit`

## Requirements
- R1: After reset, `in_ready` is 1, `res_valid` is 0 and every memory word reads 0 on the load port.
- R2: A transaction is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only while the engine is idle, and it is 0 from the cycle after acceptance until the result cycle has passed.
- R3: If every read-log value equals the current memory word at its address, the result has `res_commit`=1 and all write-log entries are stored in memory.
- R4: If any read-log value differs from memory, the result has `res_commit`=0 and memory is left unchanged.
- R5: Write-log entries are applied in index order, so when an address appears twice the entry with the higher index holds the final value.
- R6: A transaction with zero read entries and zero write entries commits, and its result appears in the cycle right after acceptance.
- R7: With acceptance on edge E0, a committing transaction shows `res_valid` after edge E0+rd+wr, where rd and wr are the log counts. An aborting one shows it after edge E0+k, where k is the 1-based index of the first read entry that mismatches.
- R8: `res_valid` is a one-cycle pulse, and `res_id` equals the `in_id` given at acceptance.
- R9: Write-log values are not visible on the load port before the transaction's write-back begins.
- R10: Each log carries 0 to 8 entries. Entry i sits at bits [i*22 +: 22] of its log bus, with the word address in bits [21:16] and the 16-bit value in bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Transaction offered |
| in_ready | output | 1 | Engine idle and able to accept |
| in_id | input | 4 | Transaction tag returned with its result |
| in_rd_cnt | input | 4 | Number of read-log entries (0..8) |
| in_rd_log | input | 176 | Read log: address and observed value per entry |
| in_wr_cnt | input | 4 | Number of write-log entries (0..8) |
| in_wr_log | input | 176 | Write log: address and new value per entry |
| res_valid | output | 1 | Result pulse |
| res_id | output | 4 | Tag of the finished transaction |
| res_commit | output | 1 | 1 = committed, 0 = aborted |
| peek_addr | input | 6 | Load-port word address |
| peek_data | output | 16 | Load-port data, combinational from memory |

## Verification
The result is due rd+wr edges after acceptance for a commit, or k edges after for an abort at the first mismatching entry k. An empty transaction answers after zero further edges. The bench computes this latency from its own reference memory before it submits each transaction. It then counts falling edges after the accepting rising edge until `res_valid` shows, and compares the count, the ID and the commit flag against its expectation. It samples the load port on the first falling edge after acceptance to confirm that nothing was written early. It also sweeps the load port against the reference memory after the directed cases and after the random run.

// File: rtl/txn_cu_pkg.sv
package txn_cu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_VALIDATE = 2'd1,
    ST_COMMIT   = 2'd2,
    ST_REPORT   = 2'd3
  } cu_state_t;
endpackage

// File: rtl/txn_word_mem.sv
module txn_word_mem #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] eng_addr,
  output logic [DW-1:0] eng_data,
  input  logic [AW-1:0] load_addr,
  output logic [DW-1:0] load_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] words [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) words[i] <= '0;
    end else if (wr_en) begin
      words[wr_addr] <= wr_data;
    end
  end

  assign eng_data  = words[eng_addr];
  assign load_data = words[load_addr];
endmodule

// File: rtl/txn_log_hold.sv
module txn_log_hold #(
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int ID_W  = 4
) (
  input  logic                        clk,
  input  logic                        load,
  input  logic [ID_W-1:0]             id_in,
  input  logic [$clog2(DEPTH+1)-1:0]  rd_cnt_in,
  input  logic [DEPTH*(AW+DW)-1:0]    rd_log_in,
  input  logic [$clog2(DEPTH+1)-1:0]  wr_cnt_in,
  input  logic [DEPTH*(AW+DW)-1:0]    wr_log_in,
  input  logic [$clog2(DEPTH+1)-1:0]  idx,
  output logic [ID_W-1:0]             id_q,
  output logic [$clog2(DEPTH+1)-1:0]  rd_cnt_q,
  output logic [$clog2(DEPTH+1)-1:0]  wr_cnt_q,
  output logic [AW-1:0]               rd_addr,
  output logic [DW-1:0]               rd_val,
  output logic [AW-1:0]               wr_addr,
  output logic [DW-1:0]               wr_val
);
  localparam int EW = AW + DW;
  localparam int CW = $clog2(DEPTH+1);

  logic [DEPTH*EW-1:0] rd_log_q, wr_log_q;

  function automatic logic [EW-1:0] pick_entry(input logic [DEPTH*EW-1:0] log_v,
                                               input logic [CW-1:0] sel);
    logic [EW-1:0] r;
    r = '0;
    for (int k = 0; k < DEPTH; k++)
      if (k == int'(sel)) r = log_v[k*EW +: EW];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (load) begin
      id_q     <= id_in;
      rd_cnt_q <= rd_cnt_in;
      wr_cnt_q <= wr_cnt_in;
      rd_log_q <= rd_log_in;
      wr_log_q <= wr_log_in;
    end
  end

  logic [EW-1:0] rd_ent, wr_ent;
  assign rd_ent  = pick_entry(rd_log_q, idx);
  assign wr_ent  = pick_entry(wr_log_q, idx);
  assign rd_addr = rd_ent[EW-1:DW];
  assign rd_val  = rd_ent[DW-1:0];
  assign wr_addr = wr_ent[EW-1:DW];
  assign wr_val  = wr_ent[DW-1:0];
endmodule

// File: rtl/txn_commit_fsm.sv
module txn_commit_fsm
  import txn_cu_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [$clog2(DEPTH+1)-1:0]  new_rd_n,
  input  logic [$clog2(DEPTH+1)-1:0]  new_wr_n,
  input  logic [$clog2(DEPTH+1)-1:0]  rd_n,
  input  logic [$clog2(DEPTH+1)-1:0]  wr_n,
  input  logic                        word_match,
  output cu_state_t                   state,
  output logic [$clog2(DEPTH+1)-1:0]  idx,
  output logic                        commit_ok,
  output logic                        mem_we,
  output logic                        mismatch
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] ONE = CW'(1);

  function automatic cu_state_t after_reads(input logic [CW-1:0] n_wr);
    return (n_wr != '0) ? ST_COMMIT : ST_REPORT;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      commit_ok <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          idx       <= '0;
          commit_ok <= 1'b1;
          state     <= (new_rd_n != '0) ? ST_VALIDATE : after_reads(new_wr_n);
        end
        ST_VALIDATE: begin
          if (!word_match) begin
            commit_ok <= 1'b0;
            state     <= ST_REPORT;
          end else if (idx == rd_n - ONE) begin
            idx   <= '0;
            state <= after_reads(wr_n);
          end else begin
            idx <= idx + ONE;
          end
        end
        ST_COMMIT: begin
          if (idx == wr_n - ONE) state <= ST_REPORT;
          else idx <= idx + ONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_we   = (state == ST_COMMIT);
  assign mismatch = (state == ST_VALIDATE) && !word_match;
endmodule

// File: rtl/txn_commit_unit.sv
module txn_commit_unit
  import txn_cu_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int ID_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [ID_W-1:0]             in_id,
  input  logic [$clog2(DEPTH+1)-1:0]  in_rd_cnt,
  input  logic [DEPTH*(AW+DW)-1:0]    in_rd_log,
  input  logic [$clog2(DEPTH+1)-1:0]  in_wr_cnt,
  input  logic [DEPTH*(AW+DW)-1:0]    in_wr_log,
  output logic                        res_valid,
  output logic [ID_W-1:0]             res_id,
  output logic                        res_commit,
  input  logic [AW-1:0]               peek_addr,
  output logic [DW-1:0]               peek_data
);
  localparam int CW = $clog2(DEPTH+1);

  cu_state_t     state;
  logic [CW-1:0] idx, rd_n, wr_n;
  logic [AW-1:0] cur_rd_addr, cur_wr_addr;
  logic [DW-1:0] cur_rd_val, cur_wr_val, mem_q;
  logic [ID_W-1:0] held_id;
  logic          start, word_match, commit_ok, mem_we, mismatch;

  assign start      = in_valid && in_ready;
  assign word_match = (mem_q == cur_rd_val);

  txn_log_hold #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .ID_W(ID_W)) u_hold (
    .clk(clk), .load(start), .id_in(in_id),
    .rd_cnt_in(in_rd_cnt), .rd_log_in(in_rd_log),
    .wr_cnt_in(in_wr_cnt), .wr_log_in(in_wr_log),
    .idx(idx), .id_q(held_id), .rd_cnt_q(rd_n), .wr_cnt_q(wr_n),
    .rd_addr(cur_rd_addr), .rd_val(cur_rd_val),
    .wr_addr(cur_wr_addr), .wr_val(cur_wr_val)
  );

  txn_word_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .eng_addr(cur_rd_addr), .eng_data(mem_q),
    .load_addr(peek_addr), .load_data(peek_data),
    .wr_en(mem_we), .wr_addr(cur_wr_addr), .wr_data(cur_wr_val)
  );

  txn_commit_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .new_rd_n(in_rd_cnt), .new_wr_n(in_wr_cnt),
    .rd_n(rd_n), .wr_n(wr_n), .word_match(word_match),
    .state(state), .idx(idx), .commit_ok(commit_ok),
    .mem_we(mem_we), .mismatch(mismatch)
  );

  assign in_ready   = (state == ST_IDLE);
  assign res_valid  = (state == ST_REPORT);
  assign res_commit = commit_ok;
  assign res_id     = held_id;
endmodule

// File: rtl/txn_commit_chk.sv
module txn_commit_chk #(
  parameter int ID_W = 4,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [CW-1:0]   in_rd_cnt,
  input logic [CW-1:0]   in_wr_cnt,
  input logic            res_valid,
  input logic            res_commit,
  input logic [ID_W-1:0] res_id,
  input logic            mem_we,
  input logic            mismatch
);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_write_only_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!in_ready && !res_valid));

  assert_mismatch_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> (res_valid && !res_commit && !mem_we));

  assert_empty_commits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_rd_cnt == '0 && in_wr_cnt == '0) |=> (res_valid && res_commit));

  assert_writeback_contiguous_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_we || (res_valid && res_commit)));

  assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_id_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !res_valid) |=> $stable(res_id));
endmodule

bind txn_commit_unit txn_commit_chk #(.ID_W(ID_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_rd_cnt(in_rd_cnt), .in_wr_cnt(in_wr_cnt),
  .res_valid(res_valid), .res_commit(res_commit), .res_id(res_id),
  .mem_we(mem_we), .mismatch(mismatch)
);

// File: tb/txn_commit_unit_tb.sv
module txn_commit_unit_tb;
  localparam int AW = 6, DW = 16, DEPTH = 8, IDW = 4, CW = 4, EW = AW + DW;
  localparam int WORDS = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, res_valid, res_commit;
  logic [IDW-1:0] in_id = '0, res_id;
  logic [CW-1:0] in_rd_cnt = '0, in_wr_cnt = '0;
  logic [DEPTH*EW-1:0] in_rd_log = '0, in_wr_log = '0;
  logic [AW-1:0] peek_addr = '0;
  logic [DW-1:0] peek_data;

  int total = 0, bad = 0;
  int ref_mem [WORDS];
  int b_ra [DEPTH], b_rv [DEPTH], b_wa [DEPTH], b_wv [DEPTH];
  int early_peek;

  always #5 clk = ~clk;

  txn_commit_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_id(in_id), .in_rd_cnt(in_rd_cnt), .in_rd_log(in_rd_log),
    .in_wr_cnt(in_wr_cnt), .in_wr_log(in_wr_log),
    .res_valid(res_valid), .res_id(res_id), .res_commit(res_commit),
    .peek_addr(peek_addr), .peek_data(peek_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int first_bad_read(input int nrd);
    for (int i = 0; i < nrd; i++)
      if (ref_mem[b_ra[i]] != b_rv[i]) return i + 1;
    return 0;
  endfunction

  task automatic send(input int id, input int nrd, input int nwr);
    int k, lat, cnt;
    bit ok;
    k   = first_bad_read(nrd);
    ok  = (k == 0);
    lat = ok ? nrd + nwr : k;
    for (int i = 0; i < DEPTH; i++) begin
      in_rd_log[i*EW +: EW] = {AW'(b_ra[i]), DW'(b_rv[i])};
      in_wr_log[i*EW +: EW] = {AW'(b_wa[i]), DW'(b_wv[i])};
    end
    @(negedge clk);
    chk(in_ready && !res_valid, "R2 idle before submit", int'(in_ready), 1);
    in_valid  = 1;
    in_id     = IDW'(id);
    in_rd_cnt = CW'(nrd);
    in_wr_cnt = CW'(nwr);
    peek_addr = AW'(b_wa[0]);
    @(posedge clk);
    #1 in_valid = 0;
    cnt = 0;
    @(negedge clk);
    early_peek = int'(peek_data);
    chk(!in_ready, "R2 busy after accept", int'(in_ready), 0);
    while (!res_valid && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == lat, "R7 result latency", cnt, lat);
    chk(res_commit == ok, ok ? "R3 commit flag" : "R4 abort flag", int'(res_commit), int'(ok));
    chk(res_id == IDW'(id), "R8 result id", int'(res_id), id & 15);
    if (ok)
      for (int i = 0; i < nwr; i++) ref_mem[b_wa[i]] = b_wv[i];
  endtask

  task automatic mem_sweep(input string req);
    for (int a = 0; a < WORDS; a++) begin
      @(negedge clk);
      peek_addr = AW'(a);
      #1 chk(int'(peek_data) == ref_mem[a], req, int'(peek_data), ref_mem[a]);
    end
  endtask

  task automatic clear_logs();
    for (int i = 0; i < DEPTH; i++) begin
      b_ra[i] = 0; b_rv[i] = 0; b_wa[i] = 0; b_wv[i] = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7151));
    for (int a = 0; a < WORDS; a++) ref_mem[a] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    chk(res_valid == 1'b0, "R1 no result after reset", int'(res_valid), 0);
    mem_sweep("R1 memory zero after reset");

    // R6: empty transaction
    clear_logs();
    send(3, 0, 0);

    // R5: duplicate write address, later entry wins (R10 packing used here)
    clear_logs();
    b_wa[0] = 5; b_wv[0] = 11; b_wa[1] = 5; b_wv[1] = 22;
    send(4, 0, 2);
    mem_sweep("R5 later write wins");

    // R3: fresh read, commit
    clear_logs();
    b_ra[0] = 5; b_rv[0] = 22; b_wa[0] = 7; b_wv[0] = 99;
    send(5, 1, 1);

    // R4: stale value at entry 2 of 3, abort after 2 cycles
    clear_logs();
    b_ra[0] = 7; b_rv[0] = 99; b_ra[1] = 5; b_rv[1] = 11; b_ra[2] = 0; b_rv[2] = 0;
    b_wa[0] = 9; b_wv[0] = 1234;
    send(6, 3, 1);
    mem_sweep("R4 memory unchanged on abort");

    // R9 and R10: full logs, write value hidden during validation
    clear_logs();
    for (int i = 0; i < DEPTH; i++) begin
      b_ra[i] = 40 + i; b_rv[i] = 0;
      b_wa[i] = 50 + i; b_wv[i] = 1000 + i;
    end
    send(15, DEPTH, DEPTH);
    chk(early_peek == 0, "R9 write hidden before write-back", early_peek, 0);
    mem_sweep("R10 full-depth logs applied");

    // random mix of commits and aborts
    for (int t = 0; t < 300; t++) begin
      int nrd, nwr;
      clear_logs();
      nrd = int'($urandom % 9);
      nwr = int'($urandom % 9);
      for (int i = 0; i < nrd; i++) begin
        b_ra[i] = int'($urandom % WORDS);
        b_rv[i] = ref_mem[b_ra[i]];
      end
      for (int i = 0; i < nwr; i++) begin
        b_wa[i] = int'($urandom % WORDS);
        b_wv[i] = int'($urandom & 32'hFFFF);
      end
      if (nrd > 0 && ($urandom % 4) == 0) begin
        int j;
        j = int'($urandom % nrd);
        b_rv[j] = (b_rv[j] + 1 + int'($urandom % 100)) & 16'hFFFF;
      end
      send(t, nrd, nwr);
    end
    mem_sweep("R3 final memory matches serial order");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule